// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Wake-Up Timing

This block takes two asynchronous control requests, one asking for a light sleep (standby) and one asking for a deep sleep (power-down). It turns them into one operating mode for a converter core. Power-down always wins over standby. Whenever the core leaves a sleep mode, the block holds a wake-up state for a fixed number of clock cycles. Only after that interval does it report the new mode as settled. The ready flag rises only when the core is back in full operation.

Each sleep mode has its own wake-up length. Both lengths are cycle-count parameters, worked out from the clock frequency. The defaults assume a 50 MHz clock: standby recovery is 800 ns (40 cycles) and power-down recovery is 1 ms (50,000 cycles).

A wake-up is cancelled at once if a sleep request comes back during it. The sequencer then returns to the requested mode. A move from power-down straight into standby is timed with the power-down length.

Top module: `lp_mode_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, mode is power-down and ready, core_en and bias_en are all low. The mode code is 2'b00 run, 2'b01 standby, 2'b10 power-down and 2'b11 waking.
- R2: Each request passes through a two-flop synchroniser. A request change driven between two rising edges first changes mode on the third rising edge after it.
- R3: With pdn_req high, mode goes to power-down whatever the level of stby_req, including from run, standby or waking.
- R4: In run, stby_req high with pdn_req low moves mode straight to standby, with no waking interval.
- R5: When both requests go low while in standby, mode is waking for exactly STBY_WAKE_CYC cycles and then run.
- R6: When both requests go low while in power-down, mode is waking for exactly PDN_WAKE_CYC cycles and then run.
- R7: Leaving power-down while stby_req is high gives waking for exactly PDN_WAKE_CYC cycles and then standby. Ready stays low for the whole of that time.
- R8: During a wake-up headed for run, a returning stby_req (pdn_req low) abandons the countdown and moves mode to standby on that edge.
- R9: During a wake-up headed for standby, a release of stby_req retargets the wake-up to run. The remaining count becomes the larger of (remaining - 1) and STBY_WAKE_CYC - 1. Run therefore follows no sooner than STBY_WAKE_CYC cycles after the retarget edge.
- R10: ready is high only in run. core_en is high in run and while waking toward run. bias_en is high in every mode except power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stby_req | input | 1 | Standby request, asynchronous |
| pdn_req | input | 1 | Power-down request, asynchronous, dominant |
| mode | output | 2 | Current operating mode code |
| ready | output | 1 | Core settled in full operation |
| core_en | output | 1 | Converter core enable |
| bias_en | output | 1 | Reference and bias enable |

## Verification
The hardest situation to reach is the retarget of a power-down-to-standby wake-up when only a few counts remain. In that case the stretch to the standby length decides when run appears. The bench releases power-down with standby held. It counts edges from the entry into waking and drops standby so that the synchronised release lands on the edge where the count reaches zero. The same edge-counting lets the bench bring back sleep requests in the middle of a wake-up, which exercises both abandon paths.

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned STBY_WAKE_CYC = 40,
  parameter int unsigned PDN_WAKE_CYC  = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_req,
  input  logic       pdn_req,
  output logic [1:0] mode,
  output logic       ready,
  output logic       core_en,
  output logic       bias_en
);
  localparam int unsigned MAX_WAKE = (PDN_WAKE_CYC > STBY_WAKE_CYC) ? PDN_WAKE_CYC : STBY_WAKE_CYC;
  localparam int unsigned CW = $clog2(MAX_WAKE + 1);
  localparam logic [CW-1:0] STBY_LD = CW'(STBY_WAKE_CYC - 1);
  localparam logic [CW-1:0] PDN_LD  = CW'(PDN_WAKE_CYC - 1);
  localparam logic [1:0] M_RUN  = 2'b00;
  localparam logic [1:0] M_STBY = 2'b01;
  localparam logic [1:0] M_PDN  = 2'b10;
  localparam logic [1:0] M_WAKE = 2'b11;

  logic [SYNC_STAGES-1:0] stby_sh, pdn_sh;
  logic                   stby_q, pdn_q;
  logic [1:0]             state, tgt, req;
  logic [CW-1:0]          cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stby_sh <= '0;
      pdn_sh  <= '1;
    end else begin
      stby_sh <= {stby_sh[SYNC_STAGES-2:0], stby_req};
      pdn_sh  <= {pdn_sh[SYNC_STAGES-2:0], pdn_req};
    end

  assign stby_q = stby_sh[SYNC_STAGES-1];
  assign pdn_q  = pdn_sh[SYNC_STAGES-1];
  assign req    = pdn_q ? M_PDN : (stby_q ? M_STBY : M_RUN);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= M_PDN;
      tgt   <= M_RUN;
      cnt   <= '0;
    end else begin
      case (state)
        M_RUN:  if (req != M_RUN) state <= req;
        M_STBY:
          if (req == M_PDN) state <= M_PDN;
          else if (req == M_RUN) begin
            state <= M_WAKE;
            tgt   <= M_RUN;
            cnt   <= STBY_LD;
          end
        M_PDN:
          if (req != M_PDN) begin
            state <= M_WAKE;
            tgt   <= req;
            cnt   <= PDN_LD;
          end
        default:
          if (req == M_PDN) state <= M_PDN;
          else if (req == M_STBY && tgt == M_RUN) state <= M_STBY;
          else if (req == M_RUN && tgt == M_STBY) begin
            tgt <= M_RUN;
            cnt <= (cnt > STBY_LD) ? cnt - 1'b1 : STBY_LD;
          end else if (cnt == '0) state <= tgt;
          else cnt <= cnt - 1'b1;
      endcase
    end

  assign mode    = state;
  assign ready   = (state == M_RUN);
  assign core_en = (state == M_RUN) || (state == M_WAKE && tgt == M_RUN);
  assign bias_en = (state != M_PDN);
endmodule

module lp_mode_ctrl_chk #(
  parameter int unsigned PDN_WAKE_CYC = 50000,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          ready,
  input logic          stby_q,
  input logic          pdn_q,
  input logic [1:0]    tgt,
  input logic [CW-1:0] cnt
);
  p_pdn_dominates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_q |=> mode == 2'b10);
  p_stby_from_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && stby_q && !pdn_q) |=> mode == 2'b01);
  p_stby_never_to_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> mode != 2'b00);
  p_pdn_only_to_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> (mode == 2'b10 || mode == 2'b11));
  p_abandon_to_stby_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && tgt == 2'b00 && stby_q && !pdn_q) |=> mode == 2'b01);
  p_ready_after_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(mode) == 2'b11);
  p_cnt_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |-> cnt < CW'(PDN_WAKE_CYC));
endmodule

bind lp_mode_ctrl lp_mode_ctrl_chk #(.PDN_WAKE_CYC(PDN_WAKE_CYC), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ready(ready),
  .stby_q(stby_q), .pdn_q(pdn_q), .tgt(tgt), .cnt(cnt)
);

// File: tb/tb_lp_mode_ctrl.sv
module tb_lp_mode_ctrl;
  localparam int SW = 6;
  localparam int PW = 15;

  logic clk = 0, rst_n = 0, stby_req = 0, pdn_req = 0;
  logic [1:0] mode;
  logic ready, core_en, bias_en;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  lp_mode_ctrl #(.SYNC_STAGES(2), .STBY_WAKE_CYC(SW), .PDN_WAKE_CYC(PW)) dut (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .pdn_req(pdn_req),
    .mode(mode), .ready(ready), .core_en(core_en), .bias_en(bias_en));

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req, input int m, input int r, input int c, input int b);
    chk({req, " mode"}, mode, m);
    chk({req, " ready"}, ready, r);
    chk({req, " core_en"}, core_en, c);
    chk({req, " bias_en"}, bias_en, b);
  endtask

  task automatic t_reset;
    rst_n = 0; stby_req = 0; pdn_req = 0;
    edges(3);
    chk_outs("R1 in reset", 2, 0, 0, 0);
    rst_n = 1;
    chk_outs("R1 after release", 2, 0, 0, 0);
  endtask

  task automatic t_pdn_to_run;
    edges(3);
    chk_outs("R2 R6 wake entry", 3, 0, 1, 1);
    edges(PW - 1);
    chk("R6 still waking", mode, 3);
    edges(1);
    chk_outs("R6 R10 run", 0, 1, 1, 1);
  endtask

  task automatic t_stby_cycle;
    stby_req = 1;
    edges(2);
    chk("R2 not yet", mode, 0);
    edges(1);
    chk_outs("R4 R10 standby", 1, 0, 0, 1);
    stby_req = 0;
    edges(3);
    chk_outs("R5 wake", 3, 0, 1, 1);
    edges(SW - 1);
    chk("R5 still waking", mode, 3);
    edges(1);
    chk("R5 run", mode, 0);
  endtask

  task automatic t_pdn_to_stby;
    stby_req = 1; pdn_req = 1;
    edges(3);
    chk_outs("R3 pdn dominates", 2, 0, 0, 0);
    pdn_req = 0;
    edges(3);
    chk_outs("R7 wake to stby", 3, 0, 0, 1);
    edges(PW - 1);
    chk("R7 still waking", mode, 3);
    chk("R7 ready low", ready, 0);
    edges(1);
    chk("R7 standby", mode, 1);
    stby_req = 0;
    edges(3 + SW);
    chk("R5 back to run", mode, 0);
  endtask

  task automatic t_abandon_pdn;
    pdn_req = 1;
    edges(3);
    chk("R3 pdn from run", mode, 2);
    pdn_req = 0;
    edges(3 + 4);
    chk("R6 mid wake", mode, 3);
    pdn_req = 1;
    edges(3);
    chk("R3 abandon to pdn", mode, 2);
    pdn_req = 0;
    edges(3 + PW);
    chk("R6 full recover", mode, 0);
  endtask

  task automatic t_abandon_stby;
    stby_req = 1;
    edges(3);
    stby_req = 0;
    edges(3 + 2);
    chk("R5 mid wake", mode, 3);
    stby_req = 1;
    edges(3);
    chk_outs("R8 abandon to stby", 1, 0, 0, 1);
    stby_req = 0;
    edges(3 + SW);
    chk("R5 recover", mode, 0);
  endtask

  task automatic t_retarget_early;
    stby_req = 1; pdn_req = 1;
    edges(3);
    pdn_req = 0;
    edges(3);
    stby_req = 0;
    edges(3);
    chk("R9 early retarget core_en", core_en, 1);
    edges(PW - 3 - 1);
    chk("R9 early still waking", mode, 3);
    edges(1);
    chk("R9 early run", mode, 0);
  endtask

  task automatic t_retarget_late;
    stby_req = 1; pdn_req = 1;
    edges(3);
    pdn_req = 0;
    edges(3);
    edges(PW - 3);
    stby_req = 0;
    edges(3);
    chk("R9 late retarget waking", mode, 3);
    edges(SW - 1);
    chk("R9 late still waking", mode, 3);
    edges(1);
    chk("R9 late run", mode, 0);
    chk("R10 ready", ready, 1);
  endtask

  initial begin
    t_reset;
    t_pdn_to_run;
    t_stby_cycle;
    t_pdn_to_stby;
    t_abandon_pdn;
    t_abandon_stby;
    t_retarget_early;
    t_retarget_late;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule